// File: doc/BRIEF.md
# Input Activity Power-Down Controller

This controller watches a wide bus of logic-array inputs. It puts the array into a low-power state once no input has toggled for a fixed idle window, and it wakes the array as soon as any input changes. The idle window is a time span, and a parameter turns it into sample-clock cycles. It holds the ceiling of the window divided by the clock period. The defaults are a 70 ns window at 20 ns per cycle, which gives 4 cycles.

Each input bit is registered once. The registered sample is then compared with the sample taken one cycle earlier. Any mismatch counts as activity and restarts the idle window. A turbo configuration pin turns the feature off: while it is high the array never powers down. Two independent clock-disable pins gate the array clock enable and the macrocell clock enable. The block has no streaming data path, so every pin is a plain level-sensitive control or status signal.

Top module: `idle_pwr_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `power_down` is 0 until the first idle window has elapsed.
- R2: Let k be the first clock edge after an input value change. With no further change and `turbo` low, `power_down` is 0 after edge k+IDLE+1 and 1 after edge k+IDLE+2. IDLE is ceil(WINDOW_PS/CLK_PERIOD_PS).
- R3: While powered down, a change on any single input bit (bit 0 and bit 60 included) drops `power_down` right after the first edge that samples it. It does not wait for the state register, and it stays low afterwards.
- R4: An input change inside a running idle window restarts the window, so the R2 timing is counted from the latest change.
- R5: While `turbo` is 1, `power_down` is 0. Raising `turbo` while powered down clears `power_down` at once, before the next clock edge.
- R6: When `turbo` falls after a full idle window with no input change, `power_down` becomes 1 after the next clock edge.
- R7: `arr_clk_en` equals 1 exactly when `arr_clk_off` is 0 and `power_down` is 0.
- R8: `mac_clk_en` equals the inverse of `mac_clk_off` and does not depend on `power_down`.
- R9: A change on many bits at once (all bits inverted) has the same timing as a change on one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| array_in | input | 61 | Monitored logic-array inputs |
| turbo | input | 1 | 1 = power-down feature defeated |
| arr_clk_off | input | 1 | 1 = array clock disabled |
| mac_clk_off | input | 1 | 1 = macrocell clock disabled |
| power_down | output | 1 | 1 = array is in low-power state |
| arr_clk_en | output | 1 | Array clock enable |
| mac_clk_en | output | 1 | Macrocell clock enable |

## Verification
The assertions take for granted that `array_in`, `turbo` and the clock-disable pins are synchronous to `clk` and settled at each rising edge. They also assume the sample and history registers start equal after reset, which holds when `array_in` is quiet during reset. The bench changes every input only a few nanoseconds after a rising edge and keeps `array_in` at zero while reset is applied. It samples outputs just after edges, and also between edges, to see the combinational wake and turbo exits.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;
  typedef enum logic {PS_AWAKE = 1'b0, PS_ASLEEP = 1'b1} pwr_state_e;

  function automatic int unsigned window_cycles(int unsigned win_ps, int unsigned per_ps);
    return (win_ps + per_ps - 1) / per_ps;
  endfunction
endpackage

// File: rtl/act_detect.sv
`timescale 1ns/1ps
module act_detect #(
  parameter int unsigned WIDTH = 61
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic             activity
);
  logic [WIDTH-1:0] samp_q, hist_q, diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      hist_q <= '0;
    end else begin
      samp_q <= din;
      hist_q <= samp_q;
    end
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign diff[g] = samp_q[g] ^ hist_q[g];
  end

  assign activity = |diff;

  // R3: a sample that differs from the previous input shows up as activity
  p_sample_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_q != $past(samp_q)) |-> activity);
endmodule

// File: rtl/idle_timer.sv
`timescale 1ns/1ps
module idle_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (restart)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired = (cnt_q == LIM);

  // R4: activity restarts the idle window
  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expired);
  // R2: the counter never passes its limit
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
endmodule

// File: rtl/clk_en_ctl.sv
`timescale 1ns/1ps
module clk_en_ctl (
  input  logic pd,
  input  logic arr_off,
  input  logic mac_off,
  output logic arr_en,
  output logic mac_en
);
  always_comb begin
    arr_en = !arr_off && !pd;
    mac_en = !mac_off;
  end
endmodule

// File: rtl/idle_pwr_ctrl.sv
`timescale 1ns/1ps
module idle_pwr_ctrl #(
  parameter int unsigned N_IN          = 61,
  parameter int unsigned WINDOW_PS     = 70000,
  parameter int unsigned CLK_PERIOD_PS = 20000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] array_in,
  input  logic            turbo,
  input  logic            arr_clk_off,
  input  logic            mac_clk_off,
  output logic            power_down,
  output logic            arr_clk_en,
  output logic            mac_clk_en
);
  import pwr_pkg::*;

  localparam int unsigned IDLE = window_cycles(WINDOW_PS, CLK_PERIOD_PS);

  logic       activity, expired;
  pwr_state_e state_q, state_d;

  act_detect #(.WIDTH(N_IN)) u_det (
    .clk(clk), .rst_n(rst_n), .din(array_in), .activity(activity)
  );

  idle_timer #(.LIMIT(IDLE)) u_tmr (
    .clk(clk), .rst_n(rst_n), .restart(activity), .expired(expired)
  );

  always_comb begin
    state_d = state_q;
    if (turbo || activity)           state_d = PS_AWAKE;
    else if (expired)                state_d = PS_ASLEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_AWAKE;
    else        state_q <= state_d;
  end

  // Combinational exit keeps the waking edge from being lost
  assign power_down = (state_q == PS_ASLEEP) && !activity && !turbo;

  clk_en_ctl u_cen (
    .pd(power_down), .arr_off(arr_clk_off), .mac_off(mac_clk_off),
    .arr_en(arr_clk_en), .mac_en(mac_clk_en)
  );

  // R3: activity always wakes
  p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    activity |-> !power_down);
  // R5: turbo keeps the array on
  p_turbo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    turbo |-> !power_down);
  // R2: sleep only follows an elapsed window
  p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == PS_ASLEEP) |-> $past(expired));
  // R7: array clock stopped while powered down
  p_arr_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    power_down |-> !arr_clk_en);
  // R8: macrocell clock follows only its own disable
  p_mac_indep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mac_clk_off |-> mac_clk_en);
endmodule

// File: tb/test_idle_pwr_ctrl.sv
`timescale 1ns/1ps
module test_idle_pwr_ctrl;
  localparam int unsigned N = 61;
  localparam int unsigned IDLE = (70000 + 20000 - 1) / 20000;

  logic clk = 0, rst_n = 0, turbo = 0, arr_off = 0, mac_off = 0;
  logic [N-1:0] ain = '0;
  logic pd, arr_en, mac_en;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  idle_pwr_ctrl i_idle_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .array_in(ain), .turbo(turbo),
    .arr_clk_off(arr_off), .mac_clk_off(mac_off),
    .power_down(pd), .arr_clk_en(arr_en), .mac_clk_en(mac_en)
  );

  task automatic check(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic go_asleep();
    ain[5] = ~ain[5];
    tick(IDLE + 3);
  endtask

  task automatic t_reset();
    #1; check("R1 pd in reset", pd, 1'b0);
    tick(2); rst_n = 1;
    tick(1); check("R1 pd after release", pd, 1'b0);
    check("R1 arr_en after release", arr_en, 1'b1);
  endtask

  task automatic t_entry();
    ain[3] = ~ain[3];
    tick(IDLE + 2); check("R2 pd before window end", pd, 1'b0);
    tick(1);        check("R2 pd at window end", pd, 1'b1);
    check("R7 arr_en gated when asleep", arr_en, 1'b0);
    check("R8 mac_en while asleep", mac_en, 1'b1);
  endtask

  task automatic t_wake(int bitn);
    go_asleep();
    check("R3 asleep before wake", pd, 1'b1);
    ain[bitn] = ~ain[bitn];
    #1; check("R3 pd before sampling edge", pd, 1'b1);
    tick(1); check($sformatf("R3 wake on bit %0d", bitn), pd, 1'b0);
    check("R7 arr_en back on wake", arr_en, 1'b1);
    tick(1); check("R3 stays awake", pd, 1'b0);
  endtask

  task automatic t_restart();
    ain[7] = ~ain[7];
    tick(IDLE);
    ain[8] = ~ain[8];
    tick(IDLE + 2); check("R4 no sleep from first change", pd, 1'b0);
    tick(1);        check("R4 sleep timed from latest change", pd, 1'b1);
  endtask

  task automatic t_multi();
    ain = ~ain;
    tick(IDLE + 2); check("R9 all-bit change before end", pd, 1'b0);
    tick(1);        check("R9 all-bit change at end", pd, 1'b1);
  endtask

  task automatic t_turbo();
    go_asleep();
    turbo = 1;
    #1; check("R5 turbo exit is immediate", pd, 1'b0);
    for (int i = 0; i < IDLE + 4; i++) begin
      tick(1); check("R5 turbo holds awake", pd, 1'b0);
    end
    turbo = 0;
    #1; check("R6 pd before next edge", pd, 1'b0);
    tick(1); check("R6 sleep one edge after turbo drops", pd, 1'b1);
  endtask

  task automatic t_clk_ctl();
    ain[0] = ~ain[0];
    tick(1);
    arr_off = 1; mac_off = 0;
    #1; check("R7 arr_off awake", arr_en, 1'b0);
    check("R8 mac_en on", mac_en, 1'b1);
    arr_off = 0; mac_off = 1;
    #1; check("R7 arr_en awake", arr_en, 1'b1);
    check("R8 mac_off awake", mac_en, 1'b0);
    tick(IDLE + 3);
    check("R8 mac_off asleep", mac_en, 1'b0);
    mac_off = 0;
    #1; check("R8 mac_en asleep", mac_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_wake(60);
    t_wake(0);
    t_restart();
    t_multi();
    t_turbo();
    t_clk_ctl();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule